// File: doc/BRIEF.md
# Triggered Quadrature Position Capture

This block follows an incremental quadrature encoder at a fast sampling clock. It also watches the encoder's side lines: two limit inputs, a setup-status input, an alarm input and a reference-mark input. All of these lines arrive without a timing relation to the clock, so each one is synchronized first. The two phase lines are then decoded into a signed 32-bit tick count. Every rising edge of an external readout trigger freezes a 64-bit snapshot and presents it with a one-cycle valid strobe. The snapshot holds the position, the current levels of the side lines, a sticky error flag and two event counters. A downstream packer can therefore take exactly one word per shot, at shot rates up to about 1 MHz.

The sticky error flag and the two counters describe what happened between clears. Alarm events and illegal phase jumps both set the error flag and add to the alarm counter. Reference-mark pulses add to a separate counter. Both counters stop at their maximum value. A synchronous clear command empties the flag and the counters and leaves the position untouched.

Top module: `quad_snap_capture`

## Requirements
- R1: While reset is held and on the first cycle after its release, `snap_valid` is 0 and `snap_word` is all zeros.
- R2: Each legal phase change moves the position by one tick, where exactly one of `quad_in[1]` and `quad_in[0]` changes. With previous value p and new value c, the step is +1 when p[1] XOR c[0] is 1 and -1 otherwise, so 00→01→11→10→00 counts up. The position wraps modulo 2^32.
- R3: A change of both phase bits in one sample leaves the position unchanged. It adds one to the alarm counter and sets the sticky error flag.
- R4: Each rising edge of `trig_in` produces exactly one `snap_valid` pulse, one cycle long. `snap_word` changes only together with that pulse and is held until the next one.
- R5: The word layout is as follows. Bits [31:0] hold the position. Bits [36:32] hold the synchronized levels of lim_lo, lim_hi, setup, alarm and ref_mark, with lim_lo in bit 32 and ref_mark in bit 36. Bit 37 holds the sticky error flag, bits [47:40] the alarm counter and bits [55:48] the reference counter. Bits 38, 39 and [63:56] are 0.
- R6: Each rising edge of `alarm_in` adds one to the alarm counter. While `alarm_in` is high, the sticky error flag is set.
- R7: Each rising edge of `ref_mark_in` adds one to the reference counter.
- R8: Both counters stop at 255 and do not wrap.
- R9: A one-cycle `clear_in` resets both counters and the sticky error flag, and the position keeps its value. An event that arrives in the same cycle as the clear is kept, so that counter reads 1 afterwards. If the alarm level is high during the clear, the flag stays set.
- R10: A phase change and a trigger edge applied in the same cycle give a snapshot that does not yet include that step. The next snapshot does include it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_in | input | 2 | Quadrature phase lines, leading phase in bit 1 |
| lim_lo_in | input | 1 | Lower travel limit level |
| lim_hi_in | input | 1 | Upper travel limit level |
| setup_in | input | 1 | Read-head setup status level |
| alarm_in | input | 1 | Encoding alarm level |
| ref_mark_in | input | 1 | Reference-mark pulse |
| trig_in | input | 1 | Readout trigger, captured on its rising edge |
| clear_in | input | 1 | Synchronous clear of flag and counters |
| snap_word | output | 64 | Packed per-shot snapshot |
| snap_valid | output | 1 | One-cycle strobe marking a new snapshot |

## Verification
Two coincidences can happen here. A trigger edge can land in the same cycle as a position step, and a clear command can land in the same cycle as an alarm edge. The bench causes the first by driving the new phase value and the trigger rise on the same clock. It then expects the old position in that snapshot and the new position in the next one. It causes the second by placing the clear exactly in the cycle in which the synchronized alarm edge is counted. It then expects an alarm count of 1 and the error flag still set.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
   localparam int WORD_W     = 64;
   localparam int POS_FIELD  = 32;
   localparam int STAT_LSB   = 32;
   localparam int STAT_W     = 5;
   localparam int LATCH_BIT  = 37;
   localparam int ALARM_LSB  = 40;
   localparam int REF_LSB    = 48;
   localparam int CNT_FIELD  = 8;

   // first member is the most significant bit
   typedef struct packed {
      logic ref_mark;
      logic alarm;
      logic setup;
      logic lim_hi;
      logic lim_lo;
   } qsc_status_t;
endpackage

// File: rtl/qsc_sync.sv
module qsc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qsc_quad_decoder.sv
module qsc_quad_decoder #(
   parameter int POS_W   = 32,
   parameter bit REVERSE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic [1:0]       quad,
   output logic [POS_W-1:0] pos,
   output logic             step_err
);
   logic [1:0] prev_q;
   logic [1:0] delta;
   logic       moved;
   logic       fwd_raw;
   logic       fwd;

   always_comb begin
      delta    = quad ^ prev_q;
      moved    = armed && (delta == 2'b01 || delta == 2'b10);
      step_err = armed && (delta == 2'b11);
      fwd_raw  = prev_q[1] ^ quad[0];
   end

   generate
      if (REVERSE) begin : g_rev
         assign fwd = ~fwd_raw;
      end else begin : g_fwd
         assign fwd = fwd_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 2'b00;
         pos    <= '0;
      end else begin
         prev_q <= quad;
         if (moved) begin
            pos <= fwd ? pos + POS_W'(1) : pos - POS_W'(1);
         end
      end
   end
endmodule

// File: rtl/qsc_sat_counter.sv
module qsc_sat_counter #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] base;
   logic [W-1:0] nxt;

   // clear first, then apply an increment from the same cycle
   assign base = clr ? '0 : count;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (inc && base != TOP) ? base + W'(1) : base;
      end else begin : g_wrap
         always_comb nxt = inc ? base + W'(1) : base;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/qsc_snap_reg.sv
module qsc_snap_reg
   import qsc_pkg::*;
#(
   parameter int POS_W = 32,
   parameter int CNT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [POS_W-1:0]    pos,
   input  qsc_status_t         status,
   input  logic                err_latch,
   input  logic [CNT_W-1:0]    alarm_cnt,
   input  logic [CNT_W-1:0]    ref_cnt,
   output logic [WORD_W-1:0]   word,
   output logic                valid
);
   logic [WORD_W-1:0] packed_word;

   always_comb begin
      packed_word                        = '0;
      packed_word[0 +: POS_W]            = pos;
      packed_word[STAT_LSB +: STAT_W]    = status;
      packed_word[LATCH_BIT]             = err_latch;
      packed_word[ALARM_LSB +: CNT_W]    = alarm_cnt;
      packed_word[REF_LSB +: CNT_W]      = ref_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= capture;
         if (capture) word <= packed_word;
      end
   end
endmodule

// File: rtl/quad_snap_capture.sv
module quad_snap_capture
   import qsc_pkg::*;
#(
   parameter int POS_W       = 32,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1,
   parameter bit REVERSE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        quad_in,
   input  logic              lim_lo_in,
   input  logic              lim_hi_in,
   input  logic              setup_in,
   input  logic              alarm_in,
   input  logic              ref_mark_in,
   input  logic              trig_in,
   input  logic              clear_in,
   output logic [63:0]       snap_word,
   output logic              snap_valid
);
   localparam int IN_W   = 8;
   localparam int SETTLE = SYNC_STAGES + 1;
   localparam int SET_W  = $clog2(SETTLE + 1);

   // elaboration checks
   if (POS_W < 2 || POS_W > POS_FIELD) begin : g_bad_pos
      $error("POS_W must lie in 2..32");
   end
   if (CNT_W < 1 || CNT_W > CNT_FIELD) begin : g_bad_cnt
      $error("CNT_W must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // synchronize every asynchronous line through the same depth
   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] syn;

   assign raw_in = {trig_in, ref_mark_in, alarm_in, setup_in,
                    lim_hi_in, lim_lo_in, quad_in};

   qsc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (syn)
   );

   logic [1:0]  quad_s;
   qsc_status_t status_s;
   logic        trig_s;

   assign quad_s          = syn[1:0];
   assign status_s.lim_lo = syn[2];
   assign status_s.lim_hi = syn[3];
   assign status_s.setup  = syn[4];
   assign status_s.alarm  = syn[5];
   assign status_s.ref_mark = syn[6];
   assign trig_s          = syn[7];

   // hold off edge detection until the synchronizers carry real samples
   logic [SET_W-1:0] settle_cnt;
   logic             armed;

   assign armed = (settle_cnt == SET_W'(SETTLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      settle_cnt <= '0;
      else if (!armed) settle_cnt <= settle_cnt + SET_W'(1);
   end

   // rising-edge detection for trigger, alarm and reference mark
   logic trig_d, alarm_d, ref_d;
   logic trig_rise, alarm_rise, ref_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_d  <= 1'b0;
         alarm_d <= 1'b0;
         ref_d   <= 1'b0;
      end else begin
         trig_d  <= trig_s;
         alarm_d <= status_s.alarm;
         ref_d   <= status_s.ref_mark;
      end
   end

   assign trig_rise  = armed & trig_s & ~trig_d;
   assign alarm_rise = armed & status_s.alarm & ~alarm_d;
   assign ref_rise   = armed & status_s.ref_mark & ~ref_d;

   // position
   logic [POS_W-1:0] pos;
   logic             step_err;

   qsc_quad_decoder #(.POS_W(POS_W), .REVERSE(REVERSE)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (armed),
      .quad    (quad_s),
      .pos     (pos),
      .step_err(step_err)
   );

   // event counters
   logic             alarm_ev;
   logic [CNT_W-1:0] alarm_cnt;
   logic [CNT_W-1:0] ref_cnt;

   assign alarm_ev = alarm_rise | step_err;

   qsc_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_alarm_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clear_in),
      .inc  (alarm_ev),
      .count(alarm_cnt)
   );

   qsc_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_ref_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clear_in),
      .inc  (ref_rise),
      .count(ref_cnt)
   );

   // sticky error flag: a set condition wins over a clear in the same cycle
   logic err_latch;
   logic err_set;

   assign err_set = step_err | (armed & status_s.alarm);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_latch <= 1'b0;
      else        err_latch <= (err_latch & ~clear_in) | err_set;
   end

   // per-shot snapshot
   qsc_snap_reg #(.POS_W(POS_W), .CNT_W(CNT_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (trig_rise),
      .pos      (pos),
      .status   (status_s),
      .err_latch(err_latch),
      .alarm_cnt(alarm_cnt),
      .ref_cnt  (ref_cnt),
      .word     (snap_word),
      .valid    (snap_valid)
   );
endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
   parameter int POS_W = 32,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             armed,
   input logic [POS_W-1:0] pos,
   input logic             step_err,
   input logic             alarm_lvl,
   input logic             clear_in,
   input logic             alarm_ev,
   input logic [CNT_W-1:0] alarm_cnt,
   input logic             err_latch,
   input logic [63:0]      snap_word,
   input logic             snap_valid
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   assert_pos_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> (pos == $past(pos)) || (pos == $past(pos) + POS_W'(1))
                || (pos == $past(pos) - POS_W'(1)));

   assert_illegal_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step_err |=> $stable(pos));

   assert_illegal_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step_err |=> err_latch);

   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid |=> !snap_valid);

   assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(snap_word) |-> snap_valid);

   assert_alarm_sets_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && alarm_lvl) |=> err_latch);

   assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_cnt == CMAX && !clear_in) |=> alarm_cnt == CMAX);

   assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_latch && !clear_in) |=> err_latch);

   assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_in && !alarm_ev) |=> alarm_cnt == '0);
endmodule

bind quad_snap_capture qsc_checker #(.POS_W(POS_W), .CNT_W(CNT_W)) u_qsc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .armed     (armed),
   .pos       (pos),
   .step_err  (step_err),
   .alarm_lvl (status_s.alarm),
   .clear_in  (clear_in),
   .alarm_ev  (alarm_ev),
   .alarm_cnt (alarm_cnt),
   .err_latch (err_latch),
   .snap_word (snap_word),
   .snap_valid(snap_valid)
);

// File: tb/quad_snap_capture_test.sv
module quad_snap_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  quad_in = 2'b00;
   logic        lim_lo_in = 1'b0, lim_hi_in = 1'b0, setup_in = 1'b0;
   logic        alarm_in = 1'b0, ref_mark_in = 1'b0, trig_in = 1'b0, clear_in = 1'b0;
   logic [63:0] snap_word;
   logic        snap_valid;

   int n_tests = 0;
   int n_fail  = 0;

   // reference model
   logic [31:0] pos_exp = '0;
   logic [7:0]  ac_exp = '0, rc_exp = '0;
   logic        lat_exp = 1'b0;
   int          ph = 0;

   always #4 clk = ~clk;

   quad_snap_capture uut (
      .clk(clk), .rst_n(rst_n), .quad_in(quad_in),
      .lim_lo_in(lim_lo_in), .lim_hi_in(lim_hi_in), .setup_in(setup_in),
      .alarm_in(alarm_in), .ref_mark_in(ref_mark_in), .trig_in(trig_in),
      .clear_in(clear_in), .snap_word(snap_word), .snap_valid(snap_valid)
   );

   function automatic logic [1:0] gray(int p);
      case (p % 4)
         0: gray = 2'b00;
         1: gray = 2'b01;
         2: gray = 2'b11;
         default: gray = 2'b10;
      endcase
   endfunction

   function automatic logic [63:0] mk(logic [31:0] p, logic [4:0] st, logic l,
                                      logic [7:0] a, logic [7:0] r);
      mk = {8'h00, r, a, 2'b00, l, st, p};
   endfunction

   function automatic logic [7:0] sat_inc(logic [7:0] v);
      sat_inc = (v == 8'hFF) ? v : v + 8'd1;
   endfunction

   function automatic logic [4:0] cur_status();
      cur_status = {ref_mark_in, alarm_in, setup_in, lim_hi_in, lim_lo_in};
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // raise the trigger (optionally with a phase change in the same cycle)
   task automatic snap(input bit move, input logic [1:0] q_new, output logic [63:0] w);
      int width;
      @(negedge clk);
      trig_in = 1'b1;
      if (move) quad_in = q_new;
      width = 0;
      w = '0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (snap_valid) begin
            width++;
            w = snap_word;
         end
      end
      trig_in = 1'b0;
      idle(3);
      check("R4 strobe count per trigger", 64'(width), 64'd1);
   endtask

   task automatic snap_check(string tag);
      logic [63:0] w;
      snap(1'b0, 2'b00, w);
      check(tag, w, mk(pos_exp, cur_status(), lat_exp, ac_exp, rc_exp));
   endtask

   task automatic step(bit up);
      ph = up ? ph + 1 : ph + 3;
      @(negedge clk);
      quad_in = gray(ph);
      pos_exp = up ? pos_exp + 32'd1 : pos_exp - 32'd1;
      idle(4);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear_in = 1'b1;
      @(negedge clk);
      clear_in = 1'b0;
      ac_exp = '0;
      rc_exp = '0;
      lat_exp = alarm_in;
      idle(2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [63:0] w;
      // R1: reset state
      idle(3);
      check("R1 word in reset", snap_word, 64'd0);
      check("R1 valid in reset", 64'(snap_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 word after release", snap_word, 64'd0);
      check("R1 valid after release", 64'(snap_valid), 64'd0);
      idle(8);
      snap_check("R5 empty snapshot");

      // R2: count up then down through zero
      for (int i = 0; i < 20; i++) begin
         step(1'b1);
         snap_check("R2 up step");
      end
      for (int i = 0; i < 45; i++) begin
         step(1'b0);
         snap_check("R2 down step wrap");
      end

      // R3: illegal jump from each of the four phases
      for (int t = 0; t < 4; t++) begin
         while ((ph % 4) != t) step(1'b1);
         ph = ph + 2;
         @(negedge clk);
         quad_in = gray(ph);
         ac_exp = sat_inc(ac_exp);
         lat_exp = 1'b1;
         idle(4);
         snap_check("R3 illegal jump");
      end

      // R9: clear keeps position
      do_clear();
      snap_check("R9 clear keeps position");

      // R5 R6 R7: sweep all side-line levels
      for (int c = 0; c < 32; c++) begin
         logic [4:0] cv;
         cv = 5'(c);
         @(negedge clk);
         if (cv[3] && !alarm_in) ac_exp = sat_inc(ac_exp);
         if (cv[4] && !ref_mark_in) rc_exp = sat_inc(rc_exp);
         if (cv[3]) lat_exp = 1'b1;
         lim_lo_in = cv[0];
         lim_hi_in = cv[1];
         setup_in = cv[2];
         alarm_in = cv[3];
         ref_mark_in = cv[4];
         idle(5);
         snap_check("R5 R6 R7 status sweep");
      end
      @(negedge clk);
      {ref_mark_in, alarm_in, setup_in, lim_hi_in, lim_lo_in} = 5'b0;
      idle(5);
      do_clear();
      snap_check("R9 clear empties flag and counters");

      // R8: saturation of both counters
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         alarm_in = 1'b1;
         ac_exp = sat_inc(ac_exp);
         lat_exp = 1'b1;
         idle(4);
         alarm_in = 1'b0;
         idle(3);
         if (i == 253) snap_check("R8 alarm count 254");
      end
      snap_check("R8 alarm count held at 255");
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         ref_mark_in = 1'b1;
         rc_exp = sat_inc(rc_exp);
         idle(4);
         ref_mark_in = 1'b0;
         idle(3);
      end
      snap_check("R8 reference count held at 255");

      // R9: clear in the same cycle as a counted alarm edge
      do_clear();
      @(negedge clk);
      alarm_in = 1'b1;
      idle(2);
      clear_in = 1'b1;
      @(negedge clk);
      clear_in = 1'b0;
      ac_exp = 8'd1;
      rc_exp = 8'd0;
      lat_exp = 1'b1;
      idle(3);
      snap_check("R9 clear coinciding with alarm edge");
      alarm_in = 1'b0;
      idle(4);
      do_clear();
      snap_check("R9 flag released after alarm low");

      // R10: trigger and phase step in the same cycle
      ph = ph + 1;
      snap(1'b1, gray(ph), w);
      check("R10 coincident snapshot excludes step", w,
            mk(pos_exp, cur_status(), lat_exp, ac_exp, rc_exp));
      pos_exp = pos_exp + 32'd1;
      snap_check("R10 next snapshot includes step");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule